// File: doc/BRIEF.md
# Multi-Port Priority Memory Arbiter

This block sits in front of a single memory command channel and decides, every clock, which of several read ports, several write ports or a periodic refresh request gets to issue next. Each port latches one request at a time into a holding slot and shows a busy flag while that slot is occupied. The winner is chosen by effective priority. That priority is a static 3-bit level per port, plus 8 while the port's boost input is high. Level 7 and anything boosted outrank refresh, and level 0 only runs when nothing else waits. Among ports of equal effective priority, a request that falls in the currently open row is preferred, and any remaining tie rotates round-robin.

Reads are answered in the order they were issued. A small return queue remembers the port, the caller's tag and the address of every read in flight. When the memory presents read data, the owning port sees a single-cycle ready pulse one clock later, together with the data, its tag and its address. The memory side is a plain valid/ready command channel plus an in-order read-data strobe.

Top module: `mem_port_arbiter`

## Requirements
- R1: A request on a port whose busy output is low is captured at the clock edge, and busy is high from the next cycle until that port's command is accepted by the channel. A request, address, tag or data presented while busy is ignored, so the command eventually issued carries the values captured first.
- R2: Effective priority is the port's 3-bit static level plus 8 while its boost input is high; boost is sampled live each cycle. A pending candidate with a higher effective priority is always issued before one with a lower effective priority, regardless of row hits.
- R3: Refresh ranks above effective priorities 1 to 6 and below 7 and above. An issued refresh appears as cmd_op 2 with cmd_port 0.
- R4: A port of effective priority 0 is issued only when no other port and no refresh has a pending, eligible request.
- R5: The open row is the address bits [ADDR_W-1:ROW_LSB] of the last accepted read or write. It is invalid after reset and after an accepted refresh. Among candidates of identical effective priority, one that hits the open row wins over one that does not.
- R6: Remaining ties are broken round-robin over the candidate order: reads 0..NUM_RD-1, then writes, then refresh. The search starts at the candidate after the last accepted one, and starts at read port 0 after reset.
- R7: A read command is offered only while fewer than RET_DEPTH reads are outstanding. A read counts as outstanding from its acceptance until its data strobe.
- R8: One cycle after mem_rvalid, exactly one rd_ready bit is high for exactly one cycle. It belongs to the port of the oldest outstanding read, and rd_data, rd_tag_out and rd_addr_out carry the memory data, that read's tag and that read's address.
- R9: While reset is asserted, every busy output, cmd_valid and every rd_ready are low.
- R10: The command fields while cmd_valid is high are: cmd_op 0 for a read and 1 for a write, cmd_port the index within that port group, cmd_addr the captured address, and, for a write, cmd_wdata the captured write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | NUM_RD | Read request per port |
| rd_addr | input | NUM_RD*ADDR_W | Read address per port, port i at [i*ADDR_W +: ADDR_W] |
| rd_tag_in | input | NUM_RD*TAG_W | Caller tag captured with the read request |
| rd_boost | input | NUM_RD | Adds 8 to the read port's priority while high |
| rd_busy | output | NUM_RD | Read slot occupied; requests ignored |
| rd_ready | output | NUM_RD | One-cycle read completion strobe per port |
| rd_data | output | DATA_W | Read data during rd_ready |
| rd_tag_out | output | TAG_W | Tag of the completed read |
| rd_addr_out | output | ADDR_W | Address of the completed read |
| wr_req | input | NUM_WR | Write request per port |
| wr_addr | input | NUM_WR*ADDR_W | Write address per port |
| wr_data | input | NUM_WR*DATA_W | Write data per port |
| wr_boost | input | NUM_WR | Adds 8 to the write port's priority while high |
| wr_busy | output | NUM_WR | Write slot occupied; requests ignored |
| refresh_req | input | 1 | Refresh wanted; held until its command is accepted |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Channel accepts the offered command this cycle |
| cmd_op | output | 2 | 0 read, 1 write, 2 refresh |
| cmd_port | output | 4 | Port index within its group |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wdata | output | DATA_W | Write data for a write command |
| mem_rvalid | input | 1 | Read data returned, in issue order |
| mem_rdata | input | DATA_W | Returned read data |

## Verification
The command choice is combinational on the holding slots, so the command fields are due in the same cycle as the slot state. The bench keeps its own model of every slot, the open row, the round-robin pointer and the outstanding count, and compares cmd_op, cmd_port, cmd_addr and cmd_wdata at the falling edge. Captures, grants and busy changes take one edge, so the model is advanced just after each rising edge and busy is compared at the following falling edge. Read completions carry one register stage, so a mem_rvalid driven before edge t is expected as a rd_ready pulse in the half cycle after edge t. It is checked at that falling edge against the oldest entry of the bench's own issue-order queue.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

   typedef enum logic [1:0] {
      MPA_OP_RD  = 2'd0,
      MPA_OP_WR  = 2'd1,
      MPA_OP_REF = 2'd2
   } mpa_op_e;

   localparam int MPA_PRIO_W = 3;
   // key = {effective priority (4), half step (1), row hit (1)}
   localparam int MPA_KEY_W  = 6;
   // refresh sits between effective levels 6 and 7
   localparam logic [MPA_KEY_W-1:0] MPA_REF_KEY = 6'b0110_1_0;

   function automatic logic [MPA_KEY_W-1:0] mpa_key(
      input logic [MPA_PRIO_W-1:0] prio,
      input logic                  boost,
      input logic                  hit
   );
      logic [3:0] eff;
      eff = {1'b0, prio} + (boost ? 4'd8 : 4'd0);
      return {eff, 1'b0, hit};
   endfunction

endpackage

// File: rtl/mpa_slot.sv
module mpa_slot #(
   parameter int ADDR_W = 12,
   parameter int PAY_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              grant,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [PAY_W-1:0]  pay_in,
   output logic              pending,
   output logic [ADDR_W-1:0] addr_q,
   output logic [PAY_W-1:0]  pay_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         addr_q  <= '0;
         pay_q   <= '0;
      end else if (!pending && req) begin
         pending <= 1'b1;
         addr_q  <= addr_in;
         pay_q   <= pay_in;
      end else if (grant) begin
         pending <= 1'b0;
      end
   end

endmodule

// File: rtl/mpa_pick.sv
module mpa_pick #(
   parameter int N      = 9,
   parameter int KEY_W  = 6,
   parameter int IDX_W  = 4,
   parameter int TIE_RR = 1
) (
   input  logic [N-1:0]       valid,
   input  logic [N*KEY_W-1:0] keys,
   input  logic [IDX_W-1:0]   rr_last,
   output logic               any,
   output logic [IDX_W-1:0]   win
);

   logic [KEY_W-1:0] best;
   logic [N-1:0]     tied;

   always_comb begin
      best = '0;
      any  = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (valid[i] && (!any || keys[i*KEY_W +: KEY_W] > best)) begin
            best = keys[i*KEY_W +: KEY_W];
            any  = 1'b1;
         end
      end
      for (int i = 0; i < N; i++) begin
         tied[i] = valid[i] && (keys[i*KEY_W +: KEY_W] == best);
      end
   end

   if (TIE_RR != 0) begin : g_rr
      always_comb begin
         logic found;
         int   idx;
         found = 1'b0;
         win   = '0;
         for (int off = 1; off <= N; off++) begin
            idx = int'(rr_last) + off;
            if (idx >= N) idx = idx - N;
            if (!found && tied[idx]) begin
               win   = IDX_W'(idx);
               found = 1'b1;
            end
         end
      end
   end else begin : g_fixed
      logic [IDX_W-1:0] rr_unused;
      assign rr_unused = rr_last;
      always_comb begin
         win = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (tied[i]) win = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/mpa_ret_fifo.sv
module mpa_ret_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = store[rptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) store[wptr] <= din;
   end

endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
   import mpa_pkg::*;
#(
   parameter int NUM_RD    = 4,
   parameter int NUM_WR    = 4,
   parameter int ADDR_W    = 12,
   parameter int ROW_LSB   = 5,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 8,
   parameter int RET_DEPTH = 4,
   parameter int TIE_RR    = 1,
   parameter logic [NUM_RD*MPA_PRIO_W-1:0] RD_PRIO = 12'h0D9,
   parameter logic [NUM_WR*MPA_PRIO_W-1:0] WR_PRIO = 12'hF9A
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_RD-1:0]        rd_req,
   input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
   input  logic [NUM_RD*TAG_W-1:0]  rd_tag_in,
   input  logic [NUM_RD-1:0]        rd_boost,
   output logic [NUM_RD-1:0]        rd_busy,
   output logic [NUM_RD-1:0]        rd_ready,
   output logic [DATA_W-1:0]        rd_data,
   output logic [TAG_W-1:0]         rd_tag_out,
   output logic [ADDR_W-1:0]        rd_addr_out,
   input  logic [NUM_WR-1:0]        wr_req,
   input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
   input  logic [NUM_WR*DATA_W-1:0] wr_data,
   input  logic [NUM_WR-1:0]        wr_boost,
   output logic [NUM_WR-1:0]        wr_busy,
   input  logic                     refresh_req,
   output logic                     cmd_valid,
   input  logic                     cmd_ready,
   output logic [1:0]               cmd_op,
   output logic [3:0]               cmd_port,
   output logic [ADDR_W-1:0]        cmd_addr,
   output logic [DATA_W-1:0]        cmd_wdata,
   input  logic                     mem_rvalid,
   input  logic [DATA_W-1:0]        mem_rdata
);

   localparam int NUM_C   = NUM_RD + NUM_WR + 1;
   localparam int REF_IDX = NUM_C - 1;
   localparam int IDX_W   = $clog2(NUM_C);
   localparam int ROW_W   = ADDR_W - ROW_LSB;
   localparam int PORT_W  = 4;
   localparam int RET_W   = PORT_W + TAG_W + ADDR_W;

   // ---------------- elaboration checks ----------------
   if (NUM_RD < 1 || NUM_RD > 16) begin : g_bad_rd
      $error("NUM_RD must be 1..16");
   end
   if (NUM_WR < 1 || NUM_WR > 16) begin : g_bad_wr
      $error("NUM_WR must be 1..16");
   end
   if (ROW_LSB < 0 || ROW_LSB >= ADDR_W) begin : g_bad_row
      $error("ROW_LSB must lie inside the address");
   end
   if (RET_DEPTH < 1 || (RET_DEPTH & (RET_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("RET_DEPTH must be a power of two");
   end

   // ---------------- candidate state ----------------
   logic [NUM_C-1:0]         c_valid;
   logic [NUM_C*MPA_KEY_W-1:0] c_keys;
   logic [ADDR_W-1:0]        c_addr [NUM_C];
   logic [TAG_W-1:0]         rd_tag_q [NUM_RD];
   logic [DATA_W-1:0]        wr_data_q [NUM_WR];
   logic [NUM_RD-1:0]        rd_pend;
   logic [NUM_WR-1:0]        wr_pend;

   logic                     any_c, fire;
   logic [IDX_W-1:0]         win, rr_last;
   logic                     open_v;
   logic [ROW_W-1:0]         open_row;
   logic                     ret_full, ret_empty;
   logic [RET_W-1:0]         ret_din, ret_dout;
   logic                     win_is_rd, win_is_wr, win_is_ref;

   for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
      logic hit;
      mpa_slot #(.ADDR_W(ADDR_W), .PAY_W(TAG_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (rd_req[g]),
         .grant   (fire && (win == IDX_W'(g))),
         .addr_in (rd_addr[g*ADDR_W +: ADDR_W]),
         .pay_in  (rd_tag_in[g*TAG_W +: TAG_W]),
         .pending (rd_pend[g]),
         .addr_q  (c_addr[g]),
         .pay_q   (rd_tag_q[g])
      );
      assign hit = open_v && (c_addr[g][ADDR_W-1:ROW_LSB] == open_row);
      assign c_valid[g] = rd_pend[g] && !ret_full;
      assign c_keys[g*MPA_KEY_W +: MPA_KEY_W] =
         mpa_key(RD_PRIO[g*MPA_PRIO_W +: MPA_PRIO_W], rd_boost[g], hit);
   end

   for (genvar g = 0; g < NUM_WR; g++) begin : g_wr
      localparam int CI = NUM_RD + g;
      logic hit;
      mpa_slot #(.ADDR_W(ADDR_W), .PAY_W(DATA_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (wr_req[g]),
         .grant   (fire && (win == IDX_W'(CI))),
         .addr_in (wr_addr[g*ADDR_W +: ADDR_W]),
         .pay_in  (wr_data[g*DATA_W +: DATA_W]),
         .pending (wr_pend[g]),
         .addr_q  (c_addr[CI]),
         .pay_q   (wr_data_q[g])
      );
      assign hit = open_v && (c_addr[CI][ADDR_W-1:ROW_LSB] == open_row);
      assign c_valid[CI] = wr_pend[g];
      assign c_keys[CI*MPA_KEY_W +: MPA_KEY_W] =
         mpa_key(WR_PRIO[g*MPA_PRIO_W +: MPA_PRIO_W], wr_boost[g], hit);
   end

   assign c_valid[REF_IDX] = refresh_req;
   assign c_keys[REF_IDX*MPA_KEY_W +: MPA_KEY_W] = MPA_REF_KEY;
   assign c_addr[REF_IDX] = '0;

   assign rd_busy = rd_pend;
   assign wr_busy = wr_pend;

   // ---------------- selection ----------------
   mpa_pick #(.N(NUM_C), .KEY_W(MPA_KEY_W), .IDX_W(IDX_W), .TIE_RR(TIE_RR)) u_pick (
      .valid   (c_valid),
      .keys    (c_keys),
      .rr_last (rr_last),
      .any     (any_c),
      .win     (win)
   );

   assign win_is_rd  = (win < IDX_W'(NUM_RD));
   assign win_is_ref = (win == IDX_W'(REF_IDX));
   assign win_is_wr  = !win_is_rd && !win_is_ref;

   assign cmd_valid = any_c;
   assign fire      = any_c && cmd_ready;

   always_comb begin
      mpa_op_e op;
      op        = MPA_OP_RD;
      cmd_port  = '0;
      cmd_wdata = '0;
      cmd_addr  = c_addr[win];
      if (win_is_ref) begin
         op = MPA_OP_REF;
      end else if (win_is_wr) begin
         op       = MPA_OP_WR;
         cmd_port = PORT_W'(win - IDX_W'(NUM_RD));
         for (int i = 0; i < NUM_WR; i++) begin
            if (win == IDX_W'(NUM_RD + i)) cmd_wdata = wr_data_q[i];
         end
      end else begin
         cmd_port = PORT_W'(win);
      end
      cmd_op = op;
   end

   // ---------------- open row and rotation ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_last  <= IDX_W'(REF_IDX);
         open_v   <= 1'b0;
         open_row <= '0;
      end else if (fire) begin
         rr_last <= win;
         if (win_is_ref) begin
            open_v <= 1'b0;
         end else begin
            open_v   <= 1'b1;
            open_row <= cmd_addr[ADDR_W-1:ROW_LSB];
         end
      end
   end

   // ---------------- read return path ----------------
   always_comb begin
      ret_din = {cmd_port, rd_tag_q[0], cmd_addr};
      for (int i = 0; i < NUM_RD; i++) begin
         if (win == IDX_W'(i)) ret_din = {cmd_port, rd_tag_q[i], cmd_addr};
      end
   end

   mpa_ret_fifo #(.DEPTH(RET_DEPTH), .W(RET_W)) u_ret (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fire && win_is_rd),
      .din   (ret_din),
      .pop   (mem_rvalid),
      .dout  (ret_dout),
      .full  (ret_full),
      .empty (ret_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ready    <= '0;
         rd_data     <= '0;
         rd_tag_out  <= '0;
         rd_addr_out <= '0;
      end else begin
         rd_ready <= '0;
         if (mem_rvalid && !ret_empty) begin
            for (int i = 0; i < NUM_RD; i++) begin
               rd_ready[i] <= (ret_dout[RET_W-1 -: PORT_W] == PORT_W'(i));
            end
            rd_data     <= mem_rdata;
            rd_tag_out  <= ret_dout[ADDR_W +: TAG_W];
            rd_addr_out <= ret_dout[ADDR_W-1:0];
         end
      end
   end

endmodule

// File: rtl/mpa_arb_checker.sv
module mpa_arb_checker #(
   parameter int NUM_RD    = 4,
   parameter int NUM_WR    = 4,
   parameter int RET_DEPTH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_RD-1:0] rd_req,
   input logic [NUM_RD-1:0] rd_busy,
   input logic [NUM_RD-1:0] rd_ready,
   input logic [NUM_WR-1:0] wr_req,
   input logic [NUM_WR-1:0] wr_busy,
   input logic              refresh_req,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_op,
   input logic [3:0]        cmd_port,
   input logic              mem_rvalid
);

   localparam int CW = $clog2(RET_DEPTH + 2);
   logic [CW-1:0] inflight;
   logic          rd_fire;

   assign rd_fire = cmd_valid && cmd_ready && (cmd_op == 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inflight <= '0;
      end else if (rd_fire && !mem_rvalid) begin
         inflight <= inflight + 1'b1;
      end else if (!rd_fire && mem_rvalid && inflight != '0) begin
         inflight <= inflight - 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_RD; g++) begin : g_rd_chk
      AST_RD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
         rd_req[g] && !rd_busy[g] |=> rd_busy[g]);                           // R1
      AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         rd_busy[g] && !(rd_fire && cmd_port == 4'(g)) |=> rd_busy[g]);      // R1
   end

   for (genvar g = 0; g < NUM_WR; g++) begin : g_wr_chk
      AST_WR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
         wr_req[g] && !wr_busy[g] |=> wr_busy[g]);                           // R1
      AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         wr_busy[g] && !(cmd_valid && cmd_ready && cmd_op == 2'd1 && cmd_port == 4'(g))
         |=> wr_busy[g]);                                                    // R1
   end

   AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !(|rd_busy) && !(|wr_busy) && !refresh_req |-> !cmd_valid);            // R4

   AST_REF_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 2'd2 |-> cmd_port == 4'd0);                     // R3

   AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_ready));                                                   // R8

   AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_ready) |-> $past(mem_rvalid));                                    // R8

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_ready) && !$past(mem_rvalid, 1) |-> 1'b0);                        // R8

   AST_RET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CW'(RET_DEPTH));                                           // R7

endmodule

bind mem_port_arbiter mpa_arb_checker #(
   .NUM_RD    (NUM_RD),
   .NUM_WR    (NUM_WR),
   .RET_DEPTH (RET_DEPTH)
) i_mpa_arb_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_req      (rd_req),
   .rd_busy     (rd_busy),
   .rd_ready    (rd_ready),
   .wr_req      (wr_req),
   .wr_busy     (wr_busy),
   .refresh_req (refresh_req),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .cmd_op      (cmd_op),
   .cmd_port    (cmd_port),
   .mem_rvalid  (mem_rvalid)
);

// File: tb/test_mem_port_arbiter.sv
module test_mem_port_arbiter;

   localparam int NUM_RD    = 4;
   localparam int NUM_WR    = 4;
   localparam int ADDR_W    = 12;
   localparam int ROW_LSB   = 5;
   localparam int DATA_W    = 32;
   localparam int TAG_W     = 8;
   localparam int RET_DEPTH = 4;
   localparam logic [NUM_RD*3-1:0] RD_PRIO = 12'h0D9; // rd0=1 rd1=3 rd2=3 rd3=0
   localparam logic [NUM_WR*3-1:0] WR_PRIO = 12'hF9A; // wr0=2 wr1=3 wr2=6 wr3=7
   localparam int NUM_C   = NUM_RD + NUM_WR + 1;
   localparam int REF_C   = NUM_C - 1;
   localparam int MEM_LAT = 5;
   localparam int NCYC    = 4000;

   logic clk = 1'b0;
   logic rst_n;
   logic [NUM_RD-1:0]        rd_req, rd_boost, rd_busy, rd_ready;
   logic [NUM_RD*ADDR_W-1:0] rd_addr;
   logic [NUM_RD*TAG_W-1:0]  rd_tag_in;
   logic [DATA_W-1:0]        rd_data;
   logic [TAG_W-1:0]         rd_tag_out;
   logic [ADDR_W-1:0]        rd_addr_out;
   logic [NUM_WR-1:0]        wr_req, wr_boost, wr_busy;
   logic [NUM_WR*ADDR_W-1:0] wr_addr;
   logic [NUM_WR*DATA_W-1:0] wr_data;
   logic                     refresh_req, cmd_valid, cmd_ready, mem_rvalid;
   logic [1:0]               cmd_op;
   logic [3:0]               cmd_port;
   logic [ADDR_W-1:0]        cmd_addr;
   logic [DATA_W-1:0]        cmd_wdata, mem_rdata;

   always #5 clk = ~clk;

   mem_port_arbiter #(
      .NUM_RD(NUM_RD), .NUM_WR(NUM_WR), .ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB),
      .DATA_W(DATA_W), .TAG_W(TAG_W), .RET_DEPTH(RET_DEPTH), .TIE_RR(1),
      .RD_PRIO(RD_PRIO), .WR_PRIO(WR_PRIO)
   ) i_mem_port_arbiter (
      .clk(clk), .rst_n(rst_n),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_tag_in(rd_tag_in), .rd_boost(rd_boost),
      .rd_busy(rd_busy), .rd_ready(rd_ready), .rd_data(rd_data),
      .rd_tag_out(rd_tag_out), .rd_addr_out(rd_addr_out),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_boost(wr_boost),
      .wr_busy(wr_busy), .refresh_req(refresh_req),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_port(cmd_port), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // ---------------- bench model ----------------
   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 0;
   bit  m_pend [NUM_C];
   logic [ADDR_W-1:0] m_addr [NUM_C];
   logic [TAG_W-1:0]  m_tag  [NUM_RD];
   logic [DATA_W-1:0] m_data [NUM_WR];
   bit  m_open_v;
   int  m_open_row;
   int  m_rr;
   int  m_out;
   int  q_port[$], q_tag[$], q_addr[$];
   int  due_cyc[$], due_addr[$];
   bit  x_rdy;
   int  x_port, x_tag, x_addr;
   logic [DATA_W-1:0] x_data;
   bit  f_v;
   int  f_idx;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] mem_word(input int a);
      return DATA_W'(a) * 32'h9E37_79B1 + 32'h1234_5678;
   endfunction

   function automatic int cand_prio(input int c);
      if (c < NUM_RD) return int'(RD_PRIO[c*3 +: 3]) + (rd_boost[c] ? 8 : 0);
      return int'(WR_PRIO[(c-NUM_RD)*3 +: 3]) + (wr_boost[c-NUM_RD] ? 8 : 0);
   endfunction

   function automatic bit cand_valid(input int c);
      if (c == REF_C) return refresh_req;
      if (c < NUM_RD) return m_pend[c] && (m_out < RET_DEPTH);
      return m_pend[c];
   endfunction

   // key = 4*effective + hit; refresh = 4*6.5
   function automatic int cand_key(input int c);
      bit hit;
      if (c == REF_C) return 26;
      hit = m_open_v && (int'(m_addr[c] >> ROW_LSB) == m_open_row);
      return cand_prio(c) * 4 + (hit ? 1 : 0);
   endfunction

   task automatic model_pick(output bit v, output int win, output string why);
      int best, ties;
      bool_loop: begin end
      v = 0; best = -1; win = 0; ties = 0; why = "R2";
      for (int c = 0; c < NUM_C; c++)
         if (cand_valid(c) && cand_key(c) > best) begin best = cand_key(c); v = 1; end
      if (!v) return;
      for (int off = 1; off <= NUM_C; off++) begin
         int c;
         c = (m_rr + off) % NUM_C;
         if (cand_valid(c) && cand_key(c) == best) begin
            if (ties == 0) win = c;
            ties++;
         end
      end
      if (win == REF_C || (refresh_req && best > 26)) why = "R3";
      else if (best / 4 == 0) why = "R4";
      else begin
         for (int c = 0; c < NUM_C; c++)
            if (c != REF_C && cand_valid(c) && cand_key(c) / 2 == best / 2 && cand_key(c) != best)
               why = "R5";
         if (why == "R2" && ties > 1) why = "R6";
      end
   endtask

   task automatic check_cycle();
      bit v; int w; string why;
      model_pick(v, w, why);
      check(cmd_valid == v, (m_out >= RET_DEPTH) ? "R7" : why, "cmd_valid", cmd_valid, v);
      if (v && cmd_valid) begin
         int eop, eport;
         eop   = (w < NUM_RD) ? 0 : (w == REF_C) ? 2 : 1;
         eport = (w < NUM_RD) ? w : (w == REF_C) ? 0 : w - NUM_RD;
         check(cmd_op == 2'(eop), why, "cmd_op", cmd_op, eop);
         check(cmd_port == 4'(eport), why, "cmd_port", cmd_port, eport);
         if (w != REF_C) check(cmd_addr == m_addr[w], "R1", "cmd_addr", cmd_addr, m_addr[w]);
         if (eop == 1) check(cmd_wdata == m_data[eport], "R10", "cmd_wdata", cmd_wdata, m_data[eport]);
      end
      for (int i = 0; i < NUM_RD; i++)
         check(rd_busy[i] == m_pend[i], "R1", $sformatf("rd_busy[%0d]", i), rd_busy[i], m_pend[i]);
      for (int i = 0; i < NUM_WR; i++)
         check(wr_busy[i] == m_pend[NUM_RD+i], "R1", $sformatf("wr_busy[%0d]", i), wr_busy[i], m_pend[NUM_RD+i]);
      for (int i = 0; i < NUM_RD; i++)
         check(rd_ready[i] == (x_rdy && x_port == i), "R8", $sformatf("rd_ready[%0d]", i),
               rd_ready[i], (x_rdy && x_port == i));
      if (x_rdy) begin
         check(rd_data == x_data, "R8", "rd_data", rd_data, x_data);
         check(rd_tag_out == TAG_W'(x_tag), "R8", "rd_tag_out", rd_tag_out, x_tag);
         check(rd_addr_out == ADDR_W'(x_addr), "R8", "rd_addr_out", rd_addr_out, x_addr);
      end
      f_v   = v && cmd_ready;
      f_idx = w;
   endtask

   task automatic update_model(input int cyc);
      bit cap [NUM_C];
      x_rdy = 0;
      if (mem_rvalid && q_port.size() > 0) begin
         x_rdy  = 1;
         x_port = q_port.pop_front();
         x_tag  = q_tag.pop_front();
         x_addr = q_addr.pop_front();
         x_data = mem_rdata;
         m_out--;
      end
      for (int c = 0; c < NUM_C - 1; c++)
         cap[c] = (c < NUM_RD ? rd_req[c] : wr_req[c-NUM_RD]) && !m_pend[c];
      if (f_v) begin
         m_rr = f_idx;
         if (f_idx == REF_C) begin
            m_open_v = 0;
            refresh_req = 1'b0;
         end else begin
            m_pend[f_idx] = 0;
            m_open_v   = 1;
            m_open_row = int'(m_addr[f_idx] >> ROW_LSB);
            if (f_idx < NUM_RD) begin
               q_port.push_back(f_idx);
               q_tag.push_back(int'(m_tag[f_idx]));
               q_addr.push_back(int'(m_addr[f_idx]));
               due_cyc.push_back(cyc + MEM_LAT);
               due_addr.push_back(int'(m_addr[f_idx]));
               m_out++;
            end
         end
      end
      for (int c = 0; c < NUM_C - 1; c++) begin
         if (cap[c]) begin
            m_pend[c] = 1;
            if (c < NUM_RD) begin
               m_addr[c] = rd_addr[c*ADDR_W +: ADDR_W];
               m_tag[c]  = rd_tag_in[c*TAG_W +: TAG_W];
            end else begin
               m_addr[c] = wr_addr[(c-NUM_RD)*ADDR_W +: ADDR_W];
               m_data[c-NUM_RD] = wr_data[(c-NUM_RD)*DATA_W +: DATA_W];
            end
         end
      end
   endtask

   function automatic logic [ADDR_W-1:0] mk_addr(input int row, input int col);
      return ADDR_W'((row << ROW_LSB) | (col & ((1 << ROW_LSB) - 1)));
   endfunction

   task automatic drive_inputs(input int cyc);
      rd_req = '0; wr_req = '0;
      if (cyc < 60) begin
         // directed corner cases
         rd_boost  = '0; wr_boost = '0;
         cmd_ready = 1'b1;
         if (cyc == 1) begin
            // everyone at once, same row, refresh too: R2 R3 R4 R6
            for (int i = 0; i < NUM_RD; i++) begin
               rd_req[i] = 1'b1;
               rd_addr[i*ADDR_W +: ADDR_W] = mk_addr(1, i);
               rd_tag_in[i*TAG_W +: TAG_W] = TAG_W'(8'hA0 + i);
            end
            for (int i = 0; i < NUM_WR; i++) begin
               wr_req[i] = 1'b1;
               wr_addr[i*ADDR_W +: ADDR_W] = mk_addr(1, 8 + i);
               wr_data[i*DATA_W +: DATA_W] = DATA_W'(32'hD000_0000 + i);
            end
            refresh_req = 1'b1;
         end
         if (cyc >= 1 && cyc < 4) cmd_ready = 1'b0;
         if (cyc == 2) rd_boost[3] = 1'b1;          // boosted level 0 beats refresh
         if (cyc == 30) begin                       // page-hit preference: R5
            rd_req[1] = 1'b1; rd_addr[1*ADDR_W +: ADDR_W] = mk_addr(5, 1);
            rd_req[2] = 1'b1; rd_addr[2*ADDR_W +: ADDR_W] = mk_addr(1, 2);
            wr_req[1] = 1'b1; wr_addr[1*ADDR_W +: ADDR_W] = mk_addr(7, 3);
         end
         if (cyc >= 30 && cyc < 33) cmd_ready = 1'b0;
         if (cyc >= 40 && cyc < 45) begin           // requests while busy ignored: R1
            rd_req[0] = 1'b1;
            rd_addr[0*ADDR_W +: ADDR_W] = mk_addr(cyc - 38, cyc);
            rd_tag_in[0*TAG_W +: TAG_W] = TAG_W'(cyc);
            cmd_ready = 1'b0;
         end
         if (cyc >= 48 && cyc < 58) begin           // read queue fills: R7
            rd_req = '1;
            for (int i = 0; i < NUM_RD; i++) rd_addr[i*ADDR_W +: ADDR_W] = mk_addr(2, cyc + i);
         end
      end else begin
         for (int i = 0; i < NUM_RD; i++) begin
            rd_req[i]   = ($urandom % 4) == 0;
            rd_boost[i] = ($urandom % 8) == 0;
            rd_addr[i*ADDR_W +: ADDR_W]  = mk_addr($urandom % 4, $urandom);
            rd_tag_in[i*TAG_W +: TAG_W]  = TAG_W'($urandom);
         end
         for (int i = 0; i < NUM_WR; i++) begin
            wr_req[i]   = ($urandom % 4) == 0;
            wr_boost[i] = ($urandom % 8) == 0;
            wr_addr[i*ADDR_W +: ADDR_W]  = mk_addr($urandom % 4, $urandom);
            wr_data[i*DATA_W +: DATA_W]  = DATA_W'($urandom);
         end
         if (!refresh_req && ($urandom % 40) == 0) refresh_req = 1'b1;
         cmd_ready = ($urandom % 4) != 0;
      end
      mem_rvalid = 1'b0;
      if (due_cyc.size() > 0 && due_cyc[0] <= cyc) begin
         void'(due_cyc.pop_front());
         mem_rvalid = 1'b1;
         mem_rdata  = mem_word(due_addr.pop_front());
      end
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5EED);
      rst_n = 1'b0;
      rd_req = '0; rd_addr = '0; rd_tag_in = '0; rd_boost = '0;
      wr_req = '0; wr_addr = '0; wr_data = '0; wr_boost = '0;
      refresh_req = 1'b0; cmd_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
      for (int c = 0; c < NUM_C; c++) begin m_pend[c] = 0; m_addr[c] = '0; end
      m_open_v = 0; m_open_row = 0; m_rr = REF_C; m_out = 0; x_rdy = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rd_busy == '0, "R9", "rd_busy in reset", rd_busy, 0);
      check(wr_busy == '0, "R9", "wr_busy in reset", wr_busy, 0);
      check(cmd_valid == 1'b0, "R9", "cmd_valid in reset", cmd_valid, 0);
      check(rd_ready == '0, "R9", "rd_ready in reset", rd_ready, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         drive_inputs(cyc);
         @(negedge clk);
         check_cycle();
         @(posedge clk); #1;
         update_model(cyc);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (NCYC + 1000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog R9: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule